// File: doc/BRIEF.md
# Block-Mode Transfer Service Flags

This block stands between a register interface and a pair of word FIFOs: an output FIFO that software fills and a serial shifter drains, and an input FIFO that the shifter fills and software drains. When a direction runs in block mode, the block raises a service flag each time software should move one block of up to four words. The number of words granted by each flag is capped by the words still left in the programmed transfer count, so a final short block is requested once fewer than four words remain.

Software starts a transfer by loading 16-bit maximum counts for both directions. This flushes both FIFOs and clears every flag. It then polls a 16-bit operational status word and acknowledges each service flag by writing a one to that flag's bit position. The block follows how many granted words are still owed in the current block and how many words are left in the transfer. When a count runs out, a done flag is set. A write to a full output FIFO is dropped and recorded as an overrun. A read from an empty input FIFO is recorded as an underrun.

Top module: `blk_svc_flags`

## Requirements
- R1: `op_status` bit positions: 4 output FIFO not empty, 5 input FIFO not empty, 6 output FIFO full, 7 input FIFO full, 8 output service, 9 input service, 10 output count done, 11 input count done, 12 output block still owed, 13 input block still owed. All other bits read 0.
- R2: The output service flag rises one cycle after all of these hold: the output mode is block, the output words left are non-zero, no granted output words are still owed, the output service flag is clear, and the output FIFO free space is at least min(4, words left). That many words are then granted.
- R3: The input service flag rises under the same rule, with the input FIFO occupancy in place of free space. A final partial block is requested when fewer than 4 words remain.
- R4: An `op_wr` with `op_wdata` bit 8 set clears the output service flag, and one with bit 9 set clears the input service flag. Other bits of the written word have no effect on either flag.
- R5: Bits 12 and 13 are high from the moment a block is granted until all of its granted words have been written or read by software.
- R6: A done flag is set on the software access that brings that direction's words left to zero. It stays set until the next load.
- R7: A mode field value of 0 (FIFO mode), 2 or 3 never raises a service flag. Only the value 1 (block mode) does.
- R8: A software write while the output FIFO is full is dropped, and `err_flags` bit 5 is set.
- R9: A software read while the input FIFO is empty sets `err_flags` bit 4.
- R10: `xfer_load` loads both counts, empties both FIFOs, and clears all status and error bits on the next cycle.
- R11: Both FIFOs return words in the order they were written.
- R12: Counts are 16 bits wide. A load of 0xFFFF grants full 4-word blocks and does not complete early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_load | input | 1 | Load counts, flush FIFOs, clear flags |
| out_max_cnt | input | 16 | Output words in the transfer |
| in_max_cnt | input | 16 | Input words in the transfer |
| out_mode_sel | input | 2 | Output transfer mode (1 = block) |
| in_mode_sel | input | 2 | Input transfer mode (1 = block) |
| op_wr | input | 1 | Write to operational status (write-one-to-clear) |
| op_wdata | input | 16 | Data written to operational status |
| sw_wr | input | 1 | Software word write to output FIFO |
| sw_wdata | input | WORD_W | Word written by software |
| sw_rd | input | 1 | Software word read from input FIFO |
| sw_rdata | output | WORD_W | Head word of input FIFO |
| sh_tx_pop | input | 1 | Shifter takes a word from output FIFO |
| sh_tx_data | output | WORD_W | Head word of output FIFO |
| sh_rx_push | input | 1 | Shifter delivers a word to input FIFO |
| sh_rx_data | input | WORD_W | Word delivered by shifter |
| op_status | output | 16 | Operational status word |
| err_flags | output | 6 | Sticky errors: bit 5 overrun, bit 4 underrun |

## Verification
A wrong words-left or owed-word counter shows up as a service flag that rises one block early or late, or as a done flag that appears on the wrong software access. Both are visible on `op_status` within one cycle of the access that should have changed them. A wrong FIFO level shows up at once in the full and not-empty bits. It also shows up one cycle later as a withheld or premature service flag when free space or occupancy sits just below or at the four-word threshold. Lost or reordered words appear on the FIFO head data when the bench drains each block.

// File: rtl/blk_svc_pkg.sv
package blk_svc_pkg;
    localparam int BLK_WORDS = 4;
    localparam int CNT_W     = 16;
    localparam int STAT_W    = 16;
    localparam int PEND_W    = $clog2(BLK_WORDS + 1);

    localparam int B_OUT_NE   = 4;
    localparam int B_IN_NE    = 5;
    localparam int B_OUT_FULL = 6;
    localparam int B_IN_FULL  = 7;
    localparam int B_OUT_SVC  = 8;
    localparam int B_IN_SVC   = 9;
    localparam int B_OUT_DONE = 10;
    localparam int B_IN_DONE  = 11;
    localparam int B_OUT_BLK  = 12;
    localparam int B_IN_BLK   = 13;

    localparam int E_OVERRUN  = 5;
    localparam int E_UNDERRUN = 4;

    typedef enum logic [1:0] {
        XFER_FIFO  = 2'd0,
        XFER_BLOCK = 2'd1,
        XFER_RSV2  = 2'd2,
        XFER_RSV3  = 2'd3
    } xfer_mode_e;

    typedef struct packed {
        logic svc;
        logic owed;
        logic done;
    } dir_flags_t;

    function automatic logic [CNT_W-1:0] blk_need(input logic [CNT_W-1:0] left);
        return (left > CNT_W'(BLK_WORDS)) ? CNT_W'(BLK_WORDS) : left;
    endfunction
endpackage

// File: rtl/blk_svc_fifo.sv
module blk_svc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wrap_inc(wp);
            if (do_pop)  rp <= wrap_inc(rp);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/blk_svc_track.sv
module blk_svc_track
    import blk_svc_pkg::*;
#(
    parameter int AVW = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             blk_en,
    input  logic [AVW-1:0]   avail,
    input  logic             consume,
    input  logic             ack,
    output dir_flags_t       flags
);
    logic [CNT_W-1:0]  left, need;
    logic [PEND_W-1:0] owed, owed_nx;
    logic              svc, done, raise;

    assign need  = blk_need(left);
    assign raise = blk_en && !svc && (left != '0) && (owed == '0)
                   && (CNT_W'(avail) >= need);

    always_comb begin
        owed_nx = owed;
        if (raise) owed_nx = PEND_W'(need);
        if (consume && owed_nx != '0) owed_nx = owed_nx - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
            owed <= '0;
            svc  <= 1'b0;
            done <= 1'b0;
        end else if (load) begin
            left <= load_val;
            owed <= '0;
            svc  <= 1'b0;
            done <= 1'b0;
        end else begin
            if (raise)    svc <= 1'b1;
            else if (ack) svc <= 1'b0;
            owed <= owed_nx;
            if (consume && left != '0) begin
                left <= left - 1'b1;
                if (left == CNT_W'(1)) done <= 1'b1;
            end
        end
    end

    assign flags.svc  = svc;
    assign flags.owed = (owed != '0);
    assign flags.done = done;
endmodule

// File: rtl/blk_svc_flags.sv
module blk_svc_flags
    import blk_svc_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_load,
    input  logic [15:0]       out_max_cnt,
    input  logic [15:0]       in_max_cnt,
    input  logic [1:0]        out_mode_sel,
    input  logic [1:0]        in_mode_sel,
    input  logic              op_wr,
    input  logic [15:0]       op_wdata,
    input  logic              sw_wr,
    input  logic [WORD_W-1:0] sw_wdata,
    input  logic              sw_rd,
    output logic [WORD_W-1:0] sw_rdata,
    input  logic              sh_tx_pop,
    output logic [WORD_W-1:0] sh_tx_data,
    input  logic              sh_rx_push,
    input  logic [WORD_W-1:0] sh_rx_data,
    output logic [15:0]       op_status,
    output logic [5:0]        err_flags
);
    localparam int LW = $clog2(FIFO_DEPTH + 1);

    logic          out_full, out_empty, in_full, in_empty;
    logic [LW-1:0] out_lvl, in_lvl, out_free;
    logic          wr_ok, rd_ok, ovr_q, unr_q;
    dir_flags_t    oflg, iflg;
    logic          unused_wbits;

    assign unused_wbits = ^{op_wdata[15:10], op_wdata[7:0]};

    assign wr_ok    = sw_wr && !out_full;
    assign rd_ok    = sw_rd && !in_empty;
    assign out_free = LW'(FIFO_DEPTH) - out_lvl;

    blk_svc_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_out_fifo (
        .clk(clk), .rst(rst), .flush(xfer_load),
        .push(sw_wr), .wdata(sw_wdata),
        .pop(sh_tx_pop), .rdata(sh_tx_data),
        .full(out_full), .empty(out_empty), .level(out_lvl)
    );

    blk_svc_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_in_fifo (
        .clk(clk), .rst(rst), .flush(xfer_load),
        .push(sh_rx_push), .wdata(sh_rx_data),
        .pop(sw_rd), .rdata(sw_rdata),
        .full(in_full), .empty(in_empty), .level(in_lvl)
    );

    blk_svc_track #(.AVW(LW)) u_out_trk (
        .clk(clk), .rst(rst), .load(xfer_load), .load_val(out_max_cnt),
        .blk_en(xfer_mode_e'(out_mode_sel) == XFER_BLOCK),
        .avail(out_free), .consume(wr_ok),
        .ack(op_wr && op_wdata[B_OUT_SVC]), .flags(oflg)
    );

    blk_svc_track #(.AVW(LW)) u_in_trk (
        .clk(clk), .rst(rst), .load(xfer_load), .load_val(in_max_cnt),
        .blk_en(xfer_mode_e'(in_mode_sel) == XFER_BLOCK),
        .avail(in_lvl), .consume(rd_ok),
        .ack(op_wr && op_wdata[B_IN_SVC]), .flags(iflg)
    );

    always_ff @(posedge clk) begin
        if (rst || xfer_load) begin
            ovr_q <= 1'b0;
            unr_q <= 1'b0;
        end else begin
            if (sw_wr && out_full) ovr_q <= 1'b1;
            if (sw_rd && in_empty) unr_q <= 1'b1;
        end
    end

    always_comb begin
        op_status             = '0;
        op_status[B_OUT_NE]   = !out_empty;
        op_status[B_IN_NE]    = !in_empty;
        op_status[B_OUT_FULL] = out_full;
        op_status[B_IN_FULL]  = in_full;
        op_status[B_OUT_SVC]  = oflg.svc;
        op_status[B_IN_SVC]   = iflg.svc;
        op_status[B_OUT_DONE] = oflg.done;
        op_status[B_IN_DONE]  = iflg.done;
        op_status[B_OUT_BLK]  = oflg.owed;
        op_status[B_IN_BLK]   = iflg.owed;
        err_flags             = '0;
        err_flags[E_OVERRUN]  = ovr_q;
        err_flags[E_UNDERRUN] = unr_q;
    end
endmodule

// File: rtl/blk_svc_flags_chk.sv
module blk_svc_flags_chk (
    input logic        clk,
    input logic        rst,
    input logic        xfer_load,
    input logic [1:0]  out_mode_sel,
    input logic        op_wr,
    input logic [15:0] op_wdata,
    input logic        sw_wr,
    input logic        sw_rd,
    input logic [15:0] op_status,
    input logic [5:0]  err_flags
);
    assert_w1c_out_R4: assert property (@(posedge clk) disable iff (rst)
        (op_wr && op_wdata[8] && op_status[8] && !xfer_load) |=> !op_status[8]);

    assert_w1c_in_R4: assert property (@(posedge clk) disable iff (rst)
        (op_wr && op_wdata[9] && op_status[9] && !xfer_load) |=> !op_status[9]);

    assert_mode_gate_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(op_status[8]) |-> ($past(out_mode_sel) == 2'd1));

    assert_blk_owed_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(op_status[8]) |-> (op_status[12] || $past(sw_wr)));

    assert_done_on_write_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(op_status[10]) |-> $past(sw_wr));

    assert_overrun_R8: assert property (@(posedge clk) disable iff (rst)
        (sw_wr && op_status[6] && !xfer_load) |=> err_flags[5]);

    assert_underrun_R9: assert property (@(posedge clk) disable iff (rst)
        (sw_rd && !op_status[5] && !xfer_load) |=> err_flags[4]);

    assert_load_clear_R10: assert property (@(posedge clk) disable iff (rst)
        xfer_load |=> (op_status == 16'h0 && err_flags == 6'h0));
endmodule

bind blk_svc_flags blk_svc_flags_chk u_chk (
    .clk(clk), .rst(rst), .xfer_load(xfer_load), .out_mode_sel(out_mode_sel),
    .op_wr(op_wr), .op_wdata(op_wdata), .sw_wr(sw_wr), .sw_rd(sw_rd),
    .op_status(op_status), .err_flags(err_flags)
);

// File: tb/tb_blk_svc_flags.sv
module tb_blk_svc_flags;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_load = 1'b0;
    logic [15:0] out_max_cnt = '0, in_max_cnt = '0;
    logic [1:0]  out_mode_sel = '0, in_mode_sel = '0;
    logic        op_wr = 1'b0;
    logic [15:0] op_wdata = '0;
    logic        sw_wr = 1'b0, sw_rd = 1'b0, sh_tx_pop = 1'b0, sh_rx_push = 1'b0;
    logic [7:0]  sw_wdata = '0, sh_rx_data = '0;
    logic [7:0]  sw_rdata, sh_tx_data;
    logic [15:0] op_status;
    logic [5:0]  err_flags;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    blk_svc_flags dut (
        .clk(clk), .rst(rst), .xfer_load(xfer_load),
        .out_max_cnt(out_max_cnt), .in_max_cnt(in_max_cnt),
        .out_mode_sel(out_mode_sel), .in_mode_sel(in_mode_sel),
        .op_wr(op_wr), .op_wdata(op_wdata),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rd(sw_rd), .sw_rdata(sw_rdata),
        .sh_tx_pop(sh_tx_pop), .sh_tx_data(sh_tx_data),
        .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data),
        .op_status(op_status), .err_flags(err_flags)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(logic [15:0] oc, logic [15:0] ic, logic [1:0] om, logic [1:0] im);
        out_max_cnt = oc; in_max_cnt = ic; out_mode_sel = om; in_mode_sel = im;
        xfer_load = 1'b1; tick(); xfer_load = 1'b0;
    endtask

    task automatic ack(logic [15:0] v);
        op_wr = 1'b1; op_wdata = v; tick(); op_wr = 1'b0; op_wdata = '0;
    endtask

    task automatic sw_push(logic [7:0] d);
        sw_wr = 1'b1; sw_wdata = d; tick(); sw_wr = 1'b0;
    endtask

    task automatic rx_push(logic [7:0] d);
        sh_rx_push = 1'b1; sh_rx_data = d; tick(); sh_rx_push = 1'b0;
    endtask

    task automatic tx_take(string req, logic [7:0] exp);
        chk(req, sh_tx_data, exp);
        sh_tx_pop = 1'b1; tick(); sh_tx_pop = 1'b0;
    endtask

    task automatic sw_take(string req, logic [7:0] exp);
        chk(req, sw_rdata, exp);
        sw_rd = 1'b1; tick(); sw_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset status", op_status, 16'h0000);
        chk("R1 reset errors", err_flags, 6'h00);
    endtask

    task automatic t_out_blocks();
        do_load(16'd6, 16'd0, 2'd1, 2'd0);
        chk("R10 status after load", op_status, 16'h0000);
        tick();
        chk("R2 first output block raised", op_status, 16'h1100);
        ack(16'h0200);
        chk("R4 other bit keeps output flag", op_status, 16'h1100);
        ack(16'h0100);
        chk("R4 output flag cleared, R5 block owed", op_status, 16'h1000);
        for (int i = 0; i < 4; i++) sw_push(8'hA0 + 8'(i));
        chk("R5 block paid, no new flag yet", op_status, 16'h0010);
        tick();
        chk("R2 partial block of 2 raised", op_status, 16'h1110);
        ack(16'h0100);
        sw_push(8'hA4);
        chk("R6 not done before last word", op_status[10], 1'b0);
        sw_push(8'hA5);
        chk("R6 output done", op_status, 16'h0410);
        for (int i = 0; i < 6; i++) tx_take("R11 output order", 8'hA0 + 8'(i));
        chk("R6 done held after drain", op_status, 16'h0400);
    endtask

    task automatic t_out_room();
        do_load(16'd12, 16'd0, 2'd1, 2'd0);
        tick();
        ack(16'h0100);
        for (int i = 0; i < 4; i++) sw_push(8'h10 + 8'(i));
        tick();
        chk("R2 second block with room 4", op_status, 16'h1110);
        ack(16'h0100);
        for (int i = 4; i < 8; i++) sw_push(8'h10 + 8'(i));
        chk("R1 output full and not empty", op_status, 16'h0050);
        tick(); tick();
        chk("R2 no flag without room", op_status, 16'h0050);
        sw_push(8'hEE);
        chk("R8 overrun flagged", err_flags, 6'h20);
        for (int i = 0; i < 3; i++) tx_take("R11 output order", 8'h10 + 8'(i));
        tick();
        chk("R2 no flag with room 3", op_status[8], 1'b0);
        tx_take("R11 output order", 8'h13);
        tick();
        chk("R2 flag after room reaches 4", op_status, 16'h1110);
        for (int i = 4; i < 8; i++) tx_take("R8 dropped word absent", 8'h10 + 8'(i));
        chk("R8 FIFO empty after drain", op_status[4], 1'b0);
    endtask

    task automatic t_in_blocks();
        do_load(16'd0, 16'd5, 2'd0, 2'd1);
        for (int i = 0; i < 3; i++) rx_push(8'hC0 + 8'(i));
        tick();
        chk("R3 no flag with 3 of 4 words", op_status, 16'h0020);
        rx_push(8'hC3);
        tick();
        chk("R3 input block raised", op_status, 16'h2220);
        ack(16'h0200);
        chk("R4 input flag cleared", op_status, 16'h2020);
        for (int i = 0; i < 4; i++) sw_take("R11 input order", 8'hC0 + 8'(i));
        chk("R5 input block paid", op_status, 16'h0000);
        rx_push(8'hC4);
        tick();
        chk("R3 partial input block of 1", op_status, 16'h2220);
        ack(16'h0200);
        sw_take("R11 input order", 8'hC4);
        chk("R6 input done", op_status, 16'h0800);
    endtask

    task automatic t_fifo_mode();
        do_load(16'd4, 16'd4, 2'd0, 2'd0);
        for (int i = 0; i < 4; i++) rx_push(8'h55);
        tick(); tick();
        chk("R7 FIFO mode gives no flags", op_status[9:8], 2'b00);
        do_load(16'd4, 16'd0, 2'd2, 2'd3);
        tick(); tick();
        chk("R7 reserved mode gives no flags", op_status, 16'h0000);
    endtask

    task automatic t_underrun_and_wide();
        do_load(16'd0, 16'd0, 2'd0, 2'd0);
        sw_rd = 1'b1; tick(); sw_rd = 1'b0;
        chk("R9 underrun flagged", err_flags, 6'h10);
        do_load(16'hFFFF, 16'd0, 2'd1, 2'd0);
        chk("R10 errors cleared by load", err_flags, 6'h00);
        tick();
        chk("R12 full block for 0xFFFF", op_status, 16'h1100);
        ack(16'h0100);
        for (int i = 0; i < 4; i++) sw_push(8'(i));
        tick();
        chk("R12 next block, not done", op_status, 16'h1110);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_out_blocks();
        t_out_room();
        t_in_blocks();
        t_fifo_mode();
        t_underrun_and_wide();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule